// File: doc/BRIEF.md
# Bridge local interrupt status and mask controller

This block collects the local interrupt events of a PCIe bridge. Each event arrives as a single-cycle hardware pulse on one bit of a 32-bit input. The pulse sets a sticky bit in a 32-bit pending register. Software clears pending bits by writing ones to them. A 32-bit enable register selects which pending bits may raise the single level-sensitive interrupt line.

The block also drives a 13-bit event vector. It holds one bit per logical event, so software can see which event fired without decoding the raw layout. In that vector:
- the eight error and doorbell bits keep their order;
- the four legacy INTx lines fold into one event;
- the four message, error-report, power and system events follow.

The low sixteen raw bits are kept for vendor DMA completion and DMA error events. They latch and can interrupt, but they have no place in the vector. Both registers sit on a simple register bus that answers reads one cycle after the request.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register, the pending register, `irq_o` and `evt_vec_o` all read 0.
- R2: A 1 on bit i of `hw_evt_i` sets pending bit i on that clock edge. This happens whether or not enable bit i is set.
- R3: A write to byte offset 0x4 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a pulse on bit i and a clear of bit i fall on the same edge, pending bit i ends at 1.
- R5: Byte offset 0x0 holds the 32-bit enable register. A full-word write replaces it, and a read returns it. A 1 enables the matching pending bit and a 0 masks it.
- R6: `irq_o` is 1 exactly when some pending bit and its enable bit are both 1. It follows the registers with one cycle of delay.
- R7: `evt_vec_o[7:0]` mirrors pending bits 23:16, one cycle after the registers, regardless of the enable register.
- R8: `evt_vec_o[8]` is the OR of pending bits 27:24, the four INTx lines.
- R9: `evt_vec_o[12:9]` mirrors pending bits 31:28.
- R10: Pending bits 15:0, the DMA completion bits 7:0 and the DMA error bits 15:8, latch and can raise `irq_o`, but never change `evt_vec_o`.
- R11: A read request gives `rsp_valid_o` high for exactly the next cycle, with the register value as it stood at the request. Any offset other than 0x0 and 0x4 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt_i | input | 32 | Event pulses, one per raw pending bit |
| req_valid_i | input | 1 | Register bus request strobe |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 4 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt: some pending bit is enabled |
| evt_vec_o | output | 13 | Compressed per-event view of pending bits |

## Verification
A pending bit stuck at 1 or lost shows up at the ports in two places. It appears on the next read of offset 0x4. Two edges after the pulse or clear that should have moved it, it also appears on `evt_vec_o` and, when enabled, on `irq_o`. A fault in the enable register shows only through `irq_o` and reads of offset 0x0, so the bench toggles enables while bits are pending. It also races clears against pulses to expose a wrong priority. Each group of raw bits is driven alone, so a misrouted vector bit shows within two cycles of its pulse.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
  localparam int RAW_W     = 32;
  localparam int DMA_DONE_W = 8;
  localparam int DMA_ERR_W  = 8;
  localparam int ERR_EVT_W  = 8;
  localparam int INTX_W     = 4;
  localparam int HI_EVT_W   = 4;
  localparam int ERR_LSB    = DMA_DONE_W + DMA_ERR_W;
  localparam int INTX_LSB   = ERR_LSB + ERR_EVT_W;
  localparam int HI_LSB     = INTX_LSB + INTX_W;
  localparam int EVT_W      = ERR_EVT_W + 1 + HI_EVT_W;
  localparam logic [3:0] OFFS_ENABLE  = 4'h0;
  localparam logic [3:0] OFFS_PENDING = 4'h4;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[b] <= 1'b0;
      else if (set_i[b])
        pend_q[b] <= 1'b1;
      else if (clr_i[b])
        pend_q[b] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2 R4
  set_latches_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_event_compress.sv
module irq_event_compress
  import bridge_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] pend_i,
  output logic [EVT_W-1:0] evt_o
);
  logic [EVT_W-1:0] evt_d;
  logic [EVT_W-1:0] evt_q;

  for (genvar e = 0; e < ERR_EVT_W; e++) begin : g_err
    assign evt_d[e] = pend_i[ERR_LSB + e];
  end

  assign evt_d[ERR_EVT_W] = |pend_i[INTX_LSB +: INTX_W];

  for (genvar h = 0; h < HI_EVT_W; h++) begin : g_hi
    assign evt_d[ERR_EVT_W + 1 + h] = pend_i[HI_LSB + h];
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  // R10
  dma_bits_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_i[INTX_LSB-1:ERR_LSB]) == '0 && $past(pend_i[INTX_LSB +: INTX_W]) == '0
     && $past(pend_i[HI_LSB +: HI_EVT_W]) == '0 && !$past(rst)) |-> (evt_q == '0));
endmodule

// File: rtl/irq_line_reduce.sv
module irq_line_reduce #(
  parameter int W     = 32,
  parameter int GRP_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  localparam int N_GRP = (W + GRP_W - 1) / GRP_W;
  localparam int PAD_W = N_GRP * GRP_W;

  logic [PAD_W-1:0] live;
  logic [N_GRP-1:0] grp_hit;
  logic             irq_q;

  assign live = PAD_W'(pend_i & en_i);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_hit[g] = |live[g*GRP_W +: GRP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |grp_hit;
  end

  assign irq_o = irq_q;

  // R6
  irq_needs_live_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past((pend_i & en_i) != '0) && !$past(rst)));

  // R6
  irq_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & en_i) == '0) |=> !irq_q);
endmodule

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl
  import bridge_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GRP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAW_W-1:0]  hw_evt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [RAW_W-1:0]  req_wdata_i,
  output logic              rsp_valid_o,
  output logic [RAW_W-1:0]  rsp_rdata_o,
  output logic              irq_o,
  output logic [EVT_W-1:0]  evt_vec_o
);
  reg_sel_e         sel;
  logic [RAW_W-1:0] en_q;
  logic [RAW_W-1:0] pend;
  logic [RAW_W-1:0] clr_vec;
  logic             rsp_valid_q;
  logic [RAW_W-1:0] rsp_rdata_q;

  always_comb begin
    if (req_addr_i == ADDR_W'(OFFS_ENABLE))       sel = SEL_ENABLE;
    else if (req_addr_i == ADDR_W'(OFFS_PENDING)) sel = SEL_PENDING;
    else                                           sel = SEL_NONE;
  end

  assign clr_vec = (req_valid_i && req_write_i && sel == SEL_PENDING) ? req_wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (req_valid_i && req_write_i && sel == SEL_ENABLE)
      en_q <= req_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      case (sel)
        SEL_ENABLE:  rsp_rdata_q <= en_q;
        SEL_PENDING: rsp_rdata_q <= pend;
        default:     rsp_rdata_q <= '0;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  irq_status_bank #(.W(RAW_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (hw_evt_i),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  irq_event_compress u_comp (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .evt_o  (evt_vec_o)
  );

  irq_line_reduce #(.W(RAW_W), .GRP_W(GRP_W)) u_line (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  // R11
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> ($past(req_valid_i && !req_write_i) && !$past(rst)));

  // R5
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFFS_ENABLE)) |=> (en_q == $past(req_wdata_i)));

  // R11
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFFS_ENABLE)) |=> $stable(en_q));
endmodule

// File: tb/bridge_irq_ctrl_tb_top.sv
module bridge_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] hw_evt = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;
  logic [12:0] evt_vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] m_pend = '0;
  logic [31:0] m_en = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bridge_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .hw_evt_i(hw_evt),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq), .evt_vec_o(evt_vec)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  // monitor: pops expected read data from the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s read: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  function automatic logic [12:0] vec_of(logic [31:0] s);
    return {s[31:28], |s[27:24], s[23:16]};
  endfunction

  task automatic rd(logic [3:0] a, string t);
    logic [31:0] e;
    e = (a == 4'h0) ? m_en : (a == 4'h4) ? m_pend : 32'h0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    if (a == 4'h0) m_en = d;
    if (a == 4'h4) m_pend = m_pend & ~d;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic pulse(logic [31:0] v);
    m_pend = m_pend | v;
    hw_evt = v;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic chk_out(string t);
    @(negedge clk);
    checks++;
    if (irq !== (|(m_pend & m_en))) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, |(m_pend & m_en));
    end
    checks++;
    if (evt_vec !== vec_of(m_pend)) begin
      errors++;
      $display("FAIL %s vec: actual %h expected %h", t, evt_vec, vec_of(m_pend));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_out("R1");
    rd(4'h0, "R1");
    rd(4'h4, "R1");

    // R2: latch while masked, no irq
    pulse(32'h0001_0000);
    chk_out("R2 R7");
    rd(4'h4, "R2");
    // R5 R6: enable it
    wr(4'h0, 32'h0001_0000);
    chk_out("R5 R6");
    rd(4'h0, "R5");
    // R8: single INTx line
    pulse(32'h0400_0000);
    chk_out("R8");
    // R9: high events
    pulse(32'hA000_0000);
    chk_out("R9");
    // R3: clear some, leave others
    wr(4'h4, 32'h0401_0000);
    chk_out("R3 R6");
    rd(4'h4, "R3");
    // R10: DMA bits latch, irq only, vector unchanged
    pulse(32'h0000_8001);
    chk_out("R10");
    wr(4'h0, 32'h0000_0001);
    chk_out("R10 R6");
    rd(4'h4, "R10");
    // R4: set and clear same edge on bit 17, clear bit 0 too
    m_pend = m_pend & ~32'h0000_0001;
    m_pend = m_pend | 32'h0002_0000;
    hw_evt = 32'h0002_0000;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h4; req_wdata = 32'h0002_0001;
    @(negedge clk);
    hw_evt = '0; req_valid = 1'b0; req_write = 1'b0;
    chk_out("R4");
    rd(4'h4, "R4");
    // R11: unmapped offset
    wr(4'h8, 32'hFFFF_FFFF);
    chk_out("R11");
    rd(4'h8, "R11");
    rd(4'h0, "R11");
    // R8: all INTx then clear all
    pulse(32'h0F00_0000);
    wr(4'h0, 32'hFFFF_FFFF);
    chk_out("R8 R6");
    wr(4'h4, 32'hFFFF_FFFF);
    chk_out("R3 R6");
    rd(4'h4, "R3");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses: actual %0d expected 0", exp_q.size());
    end
    summary();
  end
endmodule